// File: doc/BRIEF.md
# Operand Producer Map for a Pointer-Linked Instruction Window

This block sits in the decode stage of a core whose instruction window tracks dependences with forward pointers instead of renamed tags. It keeps one row per architectural register. Each row records the window entry that last wrote the register and the operand slot that last referred to it. When one instruction is decoded per cycle, the block tells the dispatcher where each source operand comes from. A source either reads the architectural register file or is supplied later by a window entry. For a source it also emits a link request, which tells the window to set the previous reference's next-use pointer to the new source slot. In this way all readers of a value form a chain that starts at the producer's destination slot.

The block saves the whole table at each predicted branch in a ring of checkpoints and restores it when the branch is found mispredicted. This removes every pointer into the squashed younger entries. When the writer of a register retires and no newer reference exists, the row is emptied, so later readers go back to the architectural register file. A slot tag is encoded as S1 = 1, S2 = 2, D = 3; the value 0 never appears in a valid link.

Top module: `consumer_map`

## Requirements
- R1: After reset every row is empty and no checkpoint is in use. A source decoded first therefore reads the architectural register file and produces no link request.
- R2: A source whose register row is empty reports `from_arf = 1` and no link request. The row stays empty, so a later reader of that register also reads the architectural register file.
- R3: A source whose row is valid reports `from_arf = 0` and the window entry of the register's last writer.
- R4: A source on a valid row raises a link request that carries the row's last reference (entry and slot tag S1=1, S2=2, D=3). The row's last reference then becomes this instruction's S1 (first source) or S2 (second source) slot.
- R5: A destination sets both pointers of its row to this instruction's entry with slot tag D. A destination alone raises no link request.
- R6: Within one instruction, source 1 is handled first, then source 2, then the destination. If source 2 names the same register as source 1, it links to this entry's S1 slot. A source that names the destination register refers to the older producer.
- R7: A retiring entry empties every row whose last reference is that entry's D slot. A source decoded in the same cycle already sees the emptied row.
- R8: A retire does not empty a row whose last reference is a newer source slot, and the row's writer pointer is kept.
- R9: An accepted branch reports the checkpoint index it takes, and the table state after the branch's own updates is saved there. A recovery naming that index restores the saved state, so that readers point again at the producers that were valid before the branch.
- R10: Decode stalls in a recovery cycle, and also for a branch when all NUM_CKPT checkpoints are in use. A stalled instruction changes no state and raises no link request.
- R11: Checkpoints are taken in ring order. A resolve frees the oldest one. A recovery frees the named checkpoint and all younger ones, so the next branch takes the recovered index again.
- R12: A retire also empties the matching rows in every saved checkpoint, so a restore never brings back a pointer to a retired writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is presented for decode |
| dec_entry | input | $clog2(WIN_DEPTH) | Window entry allocated to the instruction |
| dec_s1_en | input | 1 | First source operand is present |
| dec_s1_reg | input | $clog2(NUM_AREG) | First source register |
| dec_s2_en | input | 1 | Second source operand is present |
| dec_s2_reg | input | $clog2(NUM_AREG) | Second source register |
| dec_d_en | input | 1 | Destination is present |
| dec_d_reg | input | $clog2(NUM_AREG) | Destination register |
| dec_branch | input | 1 | Instruction is a predicted branch and needs a checkpoint |
| dec_stall | output | 1 | Instruction is not accepted this cycle |
| dec_ckpt_id | output | $clog2(NUM_CKPT) | Checkpoint index a branch takes |
| s1_from_arf | output | 1 | First source reads the architectural register file |
| s1_wr_entry | output | $clog2(WIN_DEPTH) | Producer entry of the first source |
| s2_from_arf | output | 1 | Second source reads the architectural register file |
| s2_wr_entry | output | $clog2(WIN_DEPTH) | Producer entry of the second source |
| lk1_valid | output | 1 | Link request for this entry's S1 slot |
| lk1_prev_entry | output | $clog2(WIN_DEPTH) | Entry of the previous reference to chain from |
| lk1_prev_slot | output | 2 | Slot tag of the previous reference |
| lk2_valid | output | 1 | Link request for this entry's S2 slot |
| lk2_prev_entry | output | $clog2(WIN_DEPTH) | Entry of the previous reference to chain from |
| lk2_prev_slot | output | 2 | Slot tag of the previous reference |
| ret_valid | input | 1 | A window entry retires |
| ret_entry | input | $clog2(WIN_DEPTH) | Retiring entry |
| br_resolve | input | 1 | Oldest checkpointed branch resolved correctly |
| br_recover | input | 1 | Restore from a checkpoint |
| br_recover_id | input | $clog2(NUM_CKPT) | Checkpoint to restore |

## Verification
Two functions can fall in the same cycle. A retire can empty a row while a source of that same register is being decoded, and a retire can reach a saved checkpoint in the cycle in which that checkpoint is restored. The directed part arranges both cases: a writer retires while its reader decodes, and a writer retires between a branch and the recovery to that branch. The random part mixes retires of recent entries with decodes, branches, resolves and recoveries at rates that make such overlaps frequent. A bench model applies the restore first, then the retire, then the decode, and every stall flag, source origin, writer entry, link request and checkpoint index is compared with that model.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  localparam int SLOT_W = 2;
  typedef enum logic [SLOT_W-1:0] {
    SLOT_NONE = 2'd0,
    SLOT_S1   = 2'd1,
    SLOT_S2   = 2'd2,
    SLOT_D    = 2'd3
  } slot_e;
endpackage

// File: rtl/cmap_retire.sv
// Empties every row whose last reference is the retiring entry's D slot.
module cmap_retire
  import cmap_pkg::*;
#(
  parameter int NUM_AREG  = 16,
  parameter int WIN_DEPTH = 32
) (
  input  logic                                     ret_valid,
  input  logic [$clog2(WIN_DEPTH)-1:0]             ret_entry,
  input  logic [NUM_AREG-1:0][2*$clog2(WIN_DEPTH)+SLOT_W:0] tbl_i,
  output logic [NUM_AREG-1:0][2*$clog2(WIN_DEPTH)+SLOT_W:0] tbl_o
);
  localparam int EW = $clog2(WIN_DEPTH);

  typedef struct packed {
    logic          vld;
    logic [EW-1:0] ref_e;
    slot_e         ref_s;
    logic [EW-1:0] wr_e;
  } row_t;

  row_t [NUM_AREG-1:0] t;

  always_comb begin
    t = tbl_i;
    for (int k = 0; k < NUM_AREG; k++) begin
      if (ret_valid && t[k].vld && (t[k].ref_s == SLOT_D) && (t[k].ref_e == ret_entry)) begin
        t[k] = '0;
      end
    end
    tbl_o = t;
  end
endmodule

// File: rtl/cmap_decode.sv
// Resolves one instruction's operands against the table and builds the updated table.
module cmap_decode
  import cmap_pkg::*;
#(
  parameter int NUM_AREG  = 16,
  parameter int WIN_DEPTH = 32
) (
  input  logic                                     fire,
  input  logic [$clog2(WIN_DEPTH)-1:0]             entry,
  input  logic                                     s1_en,
  input  logic [$clog2(NUM_AREG)-1:0]              s1_reg,
  input  logic                                     s2_en,
  input  logic [$clog2(NUM_AREG)-1:0]              s2_reg,
  input  logic                                     d_en,
  input  logic [$clog2(NUM_AREG)-1:0]              d_reg,
  input  logic [NUM_AREG-1:0][2*$clog2(WIN_DEPTH)+SLOT_W:0] tbl_i,
  output logic [NUM_AREG-1:0][2*$clog2(WIN_DEPTH)+SLOT_W:0] tbl_o,
  output logic                                     s1_arf,
  output logic [$clog2(WIN_DEPTH)-1:0]             s1_wr,
  output logic                                     s2_arf,
  output logic [$clog2(WIN_DEPTH)-1:0]             s2_wr,
  output logic                                     lk1_v,
  output logic [$clog2(WIN_DEPTH)-1:0]             lk1_e,
  output logic [SLOT_W-1:0]                        lk1_s,
  output logic                                     lk2_v,
  output logic [$clog2(WIN_DEPTH)-1:0]             lk2_e,
  output logic [SLOT_W-1:0]                        lk2_s
);
  localparam int EW = $clog2(WIN_DEPTH);

  typedef struct packed {
    logic          vld;
    logic [EW-1:0] ref_e;
    slot_e         ref_s;
    logic [EW-1:0] wr_e;
  } row_t;

  row_t [NUM_AREG-1:0] t;
  logic                l1, l2;

  always_comb begin
    t      = tbl_i;
    s1_arf = 1'b1;
    s1_wr  = '0;
    l1     = 1'b0;
    lk1_e  = '0;
    lk1_s  = SLOT_NONE;
    s2_arf = 1'b1;
    s2_wr  = '0;
    l2     = 1'b0;
    lk2_e  = '0;
    lk2_s  = SLOT_NONE;
    // first source
    if (s1_en) begin
      s1_arf = !t[s1_reg].vld;
      s1_wr  = t[s1_reg].wr_e;
      if (t[s1_reg].vld) begin
        l1              = 1'b1;
        lk1_e           = t[s1_reg].ref_e;
        lk1_s           = t[s1_reg].ref_s;
        t[s1_reg].ref_e = entry;
        t[s1_reg].ref_s = SLOT_S1;
      end
    end
    // second source sees the first source's update
    if (s2_en) begin
      s2_arf = !t[s2_reg].vld;
      s2_wr  = t[s2_reg].wr_e;
      if (t[s2_reg].vld) begin
        l2              = 1'b1;
        lk2_e           = t[s2_reg].ref_e;
        lk2_s           = t[s2_reg].ref_s;
        t[s2_reg].ref_e = entry;
        t[s2_reg].ref_s = SLOT_S2;
      end
    end
    // destination last
    if (d_en) begin
      t[d_reg].vld   = 1'b1;
      t[d_reg].ref_e = entry;
      t[d_reg].ref_s = SLOT_D;
      t[d_reg].wr_e  = entry;
    end
    lk1_v = fire && l1;
    lk2_v = fire && l2;
    tbl_o = fire ? t : tbl_i;
  end
endmodule

// File: rtl/cmap_ckpt_ctrl.sv
// Ring allocator for table checkpoints.
module cmap_ckpt_ctrl #(
  parameter int NUM_CKPT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic                        resolve,
  input  logic                        recover,
  input  logic [$clog2(NUM_CKPT)-1:0] recover_id,
  output logic                        full,
  output logic [$clog2(NUM_CKPT)-1:0] alloc_id
);
  localparam int CW  = $clog2(NUM_CKPT);
  localparam int CNW = CW + 1;

  logic [CW-1:0]  head_q, head_d, tail_q, tail_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           res_eff, ctl_en;

  assign full     = (cnt_q == CNW'(NUM_CKPT));
  assign alloc_id = tail_q;
  assign res_eff  = resolve && !recover && (cnt_q != '0);
  assign ctl_en   = recover || take || res_eff;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (recover) begin
      tail_d = recover_id;
      cnt_d  = {1'b0, recover_id - head_q};
    end else begin
      head_d = head_q + CW'(res_eff);
      tail_d = tail_q + CW'(take);
      cnt_d  = cnt_q + CNW'(take) - CNW'(res_eff);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (ctl_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assert_no_overalloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !full);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNW'(NUM_CKPT));
endmodule

// File: rtl/consumer_map.sv
module consumer_map
  import cmap_pkg::*;
#(
  parameter int NUM_AREG  = 16,
  parameter int WIN_DEPTH = 32,
  parameter int NUM_CKPT  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dec_valid,
  input  logic [$clog2(WIN_DEPTH)-1:0]  dec_entry,
  input  logic                          dec_s1_en,
  input  logic [$clog2(NUM_AREG)-1:0]   dec_s1_reg,
  input  logic                          dec_s2_en,
  input  logic [$clog2(NUM_AREG)-1:0]   dec_s2_reg,
  input  logic                          dec_d_en,
  input  logic [$clog2(NUM_AREG)-1:0]   dec_d_reg,
  input  logic                          dec_branch,
  output logic                          dec_stall,
  output logic [$clog2(NUM_CKPT)-1:0]   dec_ckpt_id,
  output logic                          s1_from_arf,
  output logic [$clog2(WIN_DEPTH)-1:0]  s1_wr_entry,
  output logic                          s2_from_arf,
  output logic [$clog2(WIN_DEPTH)-1:0]  s2_wr_entry,
  output logic                          lk1_valid,
  output logic [$clog2(WIN_DEPTH)-1:0]  lk1_prev_entry,
  output logic [1:0]                    lk1_prev_slot,
  output logic                          lk2_valid,
  output logic [$clog2(WIN_DEPTH)-1:0]  lk2_prev_entry,
  output logic [1:0]                    lk2_prev_slot,
  input  logic                          ret_valid,
  input  logic [$clog2(WIN_DEPTH)-1:0]  ret_entry,
  input  logic                          br_resolve,
  input  logic                          br_recover,
  input  logic [$clog2(NUM_CKPT)-1:0]   br_recover_id
);
  localparam int EW    = $clog2(WIN_DEPTH);
  localparam int CW    = $clog2(NUM_CKPT);
  localparam int ROW_W = 2 * EW + SLOT_W + 1;

  typedef logic [NUM_AREG-1:0][ROW_W-1:0] tbl_t;

  typedef struct packed {
    logic          vld;
    logic [EW-1:0] ref_e;
    slot_e         ref_s;
    logic [EW-1:0] wr_e;
  } row_t;

  tbl_t  tbl_q, base, cleared, tbl_d;
  tbl_t  snap_q   [NUM_CKPT];
  tbl_t  snap_clr [NUM_CKPT];
  logic  ckpt_full, fire, take, tbl_en;
  logic [CW-1:0] alloc_id;

  assign dec_stall   = br_recover || (dec_branch && ckpt_full);
  assign fire        = dec_valid && !dec_stall;
  assign take        = fire && dec_branch;
  assign dec_ckpt_id = alloc_id;
  assign base        = br_recover ? snap_q[br_recover_id] : tbl_q;
  assign tbl_en      = fire || ret_valid || br_recover;

  cmap_retire #(.NUM_AREG(NUM_AREG), .WIN_DEPTH(WIN_DEPTH)) u_ret_live (
    .ret_valid (ret_valid),
    .ret_entry (ret_entry),
    .tbl_i     (base),
    .tbl_o     (cleared)
  );

  cmap_decode #(.NUM_AREG(NUM_AREG), .WIN_DEPTH(WIN_DEPTH)) u_dec (
    .fire   (fire),
    .entry  (dec_entry),
    .s1_en  (dec_s1_en),
    .s1_reg (dec_s1_reg),
    .s2_en  (dec_s2_en),
    .s2_reg (dec_s2_reg),
    .d_en   (dec_d_en),
    .d_reg  (dec_d_reg),
    .tbl_i  (cleared),
    .tbl_o  (tbl_d),
    .s1_arf (s1_from_arf),
    .s1_wr  (s1_wr_entry),
    .s2_arf (s2_from_arf),
    .s2_wr  (s2_wr_entry),
    .lk1_v  (lk1_valid),
    .lk1_e  (lk1_prev_entry),
    .lk1_s  (lk1_prev_slot),
    .lk2_v  (lk2_valid),
    .lk2_e  (lk2_prev_entry),
    .lk2_s  (lk2_prev_slot)
  );

  cmap_ckpt_ctrl #(.NUM_CKPT(NUM_CKPT)) u_ckpt (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .resolve    (br_resolve),
    .recover    (br_recover),
    .recover_id (br_recover_id),
    .full       (ckpt_full),
    .alloc_id   (alloc_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tbl_q <= '0;
    else if (tbl_en) tbl_q <= tbl_d;
  end

  for (genvar g = 0; g < NUM_CKPT; g++) begin : g_snap
    tbl_t snap_d;
    logic snap_en, snap_hit;

    cmap_retire #(.NUM_AREG(NUM_AREG), .WIN_DEPTH(WIN_DEPTH)) u_ret_snap (
      .ret_valid (ret_valid),
      .ret_entry (ret_entry),
      .tbl_i     (snap_q[g]),
      .tbl_o     (snap_clr[g])
    );

    assign snap_hit = take && (alloc_id == CW'(g));
    assign snap_en  = snap_hit || ret_valid;
    assign snap_d   = snap_hit ? tbl_d : snap_clr[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q[g] <= '0;
      else if (snap_en) snap_q[g] <= snap_d;
    end
  end

  // checks on the live table
  row_t [NUM_AREG-1:0] tq_view;
  assign tq_view = tbl_q;

  function automatic logic has_d_ref(input tbl_t tb, input logic [EW-1:0] e);
    row_t [NUM_AREG-1:0] v;
    logic hit;
    v   = tb;
    hit = 1'b0;
    for (int k = 0; k < NUM_AREG; k++) begin
      if (v[k].vld && v[k].ref_s == SLOT_D && v[k].ref_e == e) hit = 1'b1;
    end
    return hit;
  endfunction

  assert_dest_sets_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec_d_en) |=> (tq_view[$past(dec_d_reg)].vld &&
                            tq_view[$past(dec_d_reg)].wr_e == $past(dec_entry) &&
                            tq_view[$past(dec_d_reg)].ref_s == SLOT_D));

  assert_link_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk1_valid |-> lk1_prev_slot != 2'd0) and (lk2_valid |-> lk2_prev_slot != 2'd0));

  assert_retire_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !(fire && dec_d_en && dec_entry == ret_entry))
      |=> !has_d_ref(tbl_q, $past(ret_entry)));
endmodule

// File: tb/sim_consumer_map.sv
module sim_consumer_map;
  localparam int NREG = 16;
  localparam int WIN  = 32;
  localparam int NCK  = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic dec_valid, dec_s1_en, dec_s2_en, dec_d_en, dec_branch;
  logic [4:0] dec_entry, ret_entry;
  logic [3:0] dec_s1_reg, dec_s2_reg, dec_d_reg;
  logic dec_stall;
  logic [1:0] dec_ckpt_id, br_recover_id;
  logic s1_from_arf, s2_from_arf, lk1_valid, lk2_valid;
  logic [4:0] s1_wr_entry, s2_wr_entry, lk1_prev_entry, lk2_prev_entry;
  logic [1:0] lk1_prev_slot, lk2_prev_slot;
  logic ret_valid, br_resolve, br_recover;

  consumer_map #(.NUM_AREG(NREG), .WIN_DEPTH(WIN), .NUM_CKPT(NCK)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_entry(dec_entry),
    .dec_s1_en(dec_s1_en), .dec_s1_reg(dec_s1_reg), .dec_s2_en(dec_s2_en),
    .dec_s2_reg(dec_s2_reg), .dec_d_en(dec_d_en), .dec_d_reg(dec_d_reg),
    .dec_branch(dec_branch), .dec_stall(dec_stall), .dec_ckpt_id(dec_ckpt_id),
    .s1_from_arf(s1_from_arf), .s1_wr_entry(s1_wr_entry),
    .s2_from_arf(s2_from_arf), .s2_wr_entry(s2_wr_entry),
    .lk1_valid(lk1_valid), .lk1_prev_entry(lk1_prev_entry), .lk1_prev_slot(lk1_prev_slot),
    .lk2_valid(lk2_valid), .lk2_prev_entry(lk2_prev_entry), .lk2_prev_slot(lk2_prev_slot),
    .ret_valid(ret_valid), .ret_entry(ret_entry), .br_resolve(br_resolve),
    .br_recover(br_recover), .br_recover_id(br_recover_id)
  );

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  // reference model: slot tags 1=S1 2=S2 3=D
  int m_v [NREG], m_re [NREG], m_rs [NREG], m_we [NREG];
  int s_v [NCK][NREG], s_re [NCK][NREG], s_rs [NCK][NREG], s_we [NCK][NREG];
  int c_head = 0, c_tail = 0, c_cnt = 0, ent = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_src(input string tag, input int r, input int slot,
                           input logic arf, input logic [4:0] wr, input logic lv,
                           input logic [4:0] le, input logic [1:0] ls);
    chk(tag, "from_arf", int'(arf), (m_v[r] != 0) ? 0 : 1);
    if (m_v[r] != 0) begin
      chk(tag, "wr_entry", int'(wr), m_we[r]);
      chk(tag, "link_valid", int'(lv), 1);
      chk(tag, "link_prev_entry", int'(le), m_re[r]);
      chk(tag, "link_prev_slot", int'(ls), m_rs[r]);
      m_re[r] = ent;
      m_rs[r] = slot;
    end else begin
      chk(tag, "link_valid", int'(lv), 0);
    end
  endtask

  task automatic step(input string tag, input bit v, input bit s1e, input int s1r,
                      input bit s2e, input int s2r, input bit de, input int dr,
                      input bit br, input bit res, input bit rec, input int rid,
                      input bit rv, input int re);
    bit stall_e, fire_e, r_eff;
    @(negedge clk);
    dec_valid = v; dec_entry = 5'(ent);
    dec_s1_en = s1e; dec_s1_reg = 4'(s1r);
    dec_s2_en = s2e; dec_s2_reg = 4'(s2r);
    dec_d_en = de; dec_d_reg = 4'(dr); dec_branch = br;
    br_resolve = res; br_recover = rec; br_recover_id = 2'(rid);
    ret_valid = rv; ret_entry = 5'(re);
    #1;
    if (rec) begin
      for (int k = 0; k < NREG; k++) begin
        m_v[k] = s_v[rid][k]; m_re[k] = s_re[rid][k];
        m_rs[k] = s_rs[rid][k]; m_we[k] = s_we[rid][k];
      end
    end
    if (rv) begin
      for (int k = 0; k < NREG; k++) begin
        if (m_v[k] != 0 && m_rs[k] == 3 && m_re[k] == re) begin
          m_v[k] = 0; m_re[k] = 0; m_rs[k] = 0; m_we[k] = 0;
        end
        for (int c = 0; c < NCK; c++) begin
          if (s_v[c][k] != 0 && s_rs[c][k] == 3 && s_re[c][k] == re) begin
            s_v[c][k] = 0; s_re[c][k] = 0; s_rs[c][k] = 0; s_we[c][k] = 0;
          end
        end
      end
    end
    stall_e = rec || (br && c_cnt == NCK);
    chk(tag, "stall", int'(dec_stall), int'(stall_e));
    fire_e = v && !stall_e;
    if (fire_e) begin
      if (s1e) model_src(tag, s1r, 1, s1_from_arf, s1_wr_entry, lk1_valid, lk1_prev_entry, lk1_prev_slot);
      else chk(tag, "link1_valid", int'(lk1_valid), 0);
      if (s2e) model_src(tag, s2r, 2, s2_from_arf, s2_wr_entry, lk2_valid, lk2_prev_entry, lk2_prev_slot);
      else chk(tag, "link2_valid", int'(lk2_valid), 0);
      if (de) begin
        m_v[dr] = 1; m_re[dr] = ent; m_rs[dr] = 3; m_we[dr] = ent;
      end
      if (br) begin
        chk(tag, "ckpt_id", int'(dec_ckpt_id), c_tail);
        for (int k = 0; k < NREG; k++) begin
          s_v[c_tail][k] = m_v[k]; s_re[c_tail][k] = m_re[k];
          s_rs[c_tail][k] = m_rs[k]; s_we[c_tail][k] = m_we[k];
        end
      end
    end else begin
      chk(tag, "no_link_when_idle", int'(lk1_valid || lk2_valid), 0);
    end
    if (rec) begin
      c_tail = rid;
      c_cnt  = (rid - c_head + NCK) % NCK;
    end else begin
      r_eff  = res && c_cnt > 0;
      c_head = (c_head + int'(r_eff)) % NCK;
      c_tail = (c_tail + int'(fire_e && br)) % NCK;
      c_cnt  = c_cnt + int'(fire_e && br) - int'(r_eff);
    end
    if (fire_e) ent = (ent + 1) % WIN;
  endtask

  // shorthands
  task automatic rd(input string tag, input int a, input int b);
    step(tag, 1, 1, a, b >= 0, (b >= 0) ? b : 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input string tag, input int d);
    step(tag, 1, 0, 0, 0, 0, 1, d, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin : main
    int seed, e_wr, e_br, tmp;
    seed = $urandom(32'd2718);
    for (int k = 0; k < NREG; k++) begin
      m_v[k] = 0; m_re[k] = 0; m_rs[k] = 0; m_we[k] = 0;
      for (int c = 0; c < NCK; c++) begin
        s_v[c][k] = 0; s_re[c][k] = 0; s_rs[c][k] = 0; s_we[c][k] = 0;
      end
    end
    rst_n = 1'b0;
    dec_valid = 0; dec_entry = 0; dec_s1_en = 0; dec_s1_reg = 0; dec_s2_en = 0;
    dec_s2_reg = 0; dec_d_en = 0; dec_d_reg = 0; dec_branch = 0; br_resolve = 0;
    br_recover = 0; br_recover_id = 0; ret_valid = 0; ret_entry = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd("R1", 5, 6);                       // fresh table: both from ARF
    rd("R2", 5, -1);                      // still empty after a read
    wr("R5", 3);                          // entry 2 writes r3
    rd("R3", 3, -1);                      // link to (2,D)
    step("R4", 1, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0); // S2 links to previous S1
    step("R6", 1, 1, 3, 1, 3, 1, 3, 0, 0, 0, 0, 0, 0); // same reg read twice and written
    rd("R6", 3, -1);                      // new writer seen
    e_wr = ent - 1;
    step("R8", 1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1, e_wr - 1); // newer refs exist
    rd("R8", 3, -1);
    wr("R7", 9);
    e_wr = ent - 1;
    step("R7", 1, 1, 9, 0, 0, 0, 0, 0, 0, 0, 0, 1, e_wr); // retire + read same cycle
    // checkpoint and recovery
    e_br = c_tail;
    step("R9", 1, 1, 3, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    wr("R9", 3);
    step("R10", 1, 1, 3, 0, 0, 0, 0, 0, 0, 1, e_br, 0, 0); // recover cycle stalls
    rd("R9", 3, -1);                      // back to the older producer
    // fill all checkpoints, then one more branch
    for (int i = 0; i < NCK; i++) step("R10", 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R10", 1, 1, 3, 0, 0, 1, 4, 1, 0, 0, 0, 0, 0);
    rd("R10", 4, -1);                     // stalled write left r4 untouched
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R11", 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    tmp = (c_head + 1) % NCK;
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, tmp, 0, 0);
    step("R11", 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0); // takes recovered index
    // retire reaches a saved checkpoint
    for (int i = 0; i < NCK; i++) step("R12", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    wr("R12", 12);
    e_wr = ent - 1;
    e_br = c_tail;
    step("R12", 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, e_wr);
    step("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, e_br, 0, 0);
    rd("R12", 12, -1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit rv, rec;
      int rid, re;
      rec = (c_cnt > 0) && ($urandom % 16 == 0);
      rid = (c_cnt > 0) ? (c_head + int'($urandom % c_cnt)) % NCK : 0;
      rv  = ($urandom % 3 == 0);
      re  = (ent + WIN - 1 - int'($urandom % 6)) % WIN;
      step("R4", ($urandom % 4) != 0, $urandom % 2 == 0, int'($urandom % NREG),
           $urandom % 2 == 0, int'($urandom % NREG), $urandom % 2 == 0,
           int'($urandom % NREG), $urandom % 5 == 0, $urandom % 4 == 0,
           rec, rid, rv, re);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule